// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM. A requester presents an address, a read/write flag, write data and a per-byte lane mask with a valid/ready handshake. The sequencer turns each accepted request into a control waveform for the RAM. That waveform covers the active-low primary select, the active-high secondary select, the active-low write strobe, the active-low output enable, the active-low byte enables, the address and the enable for the controller's own data drivers. Every minimum time is given in nanoseconds as a parameter. The block converts each one into a clock-cycle count, rounding up against the clock period.

Each access runs through four phases. In the prepare phase the address and selects settle while the write strobe stays high. In the strobe phase either the write strobe or the output enable is held low. In the release phase both are high again. The sequencer then idles, or it starts the next access at once. Read data is sampled on the last cycle of the strobe phase and returned with a single-cycle response pulse. A write takes effect at the rise of the write strobe while both selects are still active, so the write strobe is always the edge that ends it.

Top module: `asram_seq`

## Requirements
- R1: In reset and when idle, the RAM is deselected: primary select high, secondary select low, write strobe, output enable and all byte enables high, data drivers off, request ready high, no response pulse.
- R2: The RAM address never changes while the write strobe is low.
- R3: The write strobe stays low for at least ceil(WP_NS/CLK_NS) cycles.
- R4: Write data is driven and unchanged for at least ceil(DW_NS/CLK_NS) cycles before the write strobe rises, and is still driven in the cycle after the rise.
- R5: Accepted requests are spaced by at least ceil(WC_NS/CLK_NS) cycles after a write and ceil(RC_NS/CLK_NS) cycles after a read.
- R6: The output enable is low only for reads, with the write strobe high and the data drivers off.
- R7: A read returns, as one single-cycle response pulse, the RAM data sampled after the address has been stable for at least ceil(AA_NS/CLK_NS) cycles. Lanes outside the mask read as zero from the bench RAM.
- R8: Byte enable i is low during an access exactly when mask bit i is set (bit 0 is bits 7:0 of the data, bit 1 is bits 15:8). A write changes only the masked lanes.
- R9: A request that is held valid is accepted in the release cycle. The spacing is then exactly the strobe length plus two cycles, with no idle cycle in between.
- R10: When the write strobe rises, both selects are still active.
- R11: Each read gives exactly one response and each write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte lane mask, bit i = byte i |
| rspValid | output | 1 | One-cycle read data pulse |
| rspData | output | DATA_W | Read data |
| sramAddr | output | ADDR_W | RAM address |
| sramCe1N | output | 1 | Primary select, active low |
| sramCe2 | output | 1 | Secondary select, active high |
| sramWeN | output | 1 | Write strobe, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramByteN | output | DATA_W/8 | Byte enables, active low |
| sramDout | output | DATA_W | Data toward the RAM |
| sramDoe | output | 1 | Drive enable for sramDout |
| sramDin | input | DATA_W | Data from the RAM |

## Verification
The hardest case to reach is a read accepted in the release cycle of the previous access. In that case the response pulse, the address change and the next prepare phase all fall within two edges. The random stimulus often holds requests valid with no gap, which produces this overlap under every pairing of reads and writes. The behavioural RAM returns a poison value until the address has aged the full access count. It also measures the strobe width and the data age at each rising write edge, so a strobe phase one cycle too short shows up as wrong data or as a timing failure.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seqState_t;

  // take is combinational (request accepted this edge); the rest are
  // registered pin-level strobes
  typedef struct packed {
    logic take;
    logic select;
    logic weOn;
    logic oeOn;
    logic drive;
    logic capture;
  } seqStrb_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 50,
  parameter int DW_NS  = 30,
  parameter int WC_NS  = 70,
  parameter int AA_NS  = 70,
  parameter int RC_NS  = 70
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output seqStrb_t strb
);

  localparam int WP_C   = ceilDiv(WP_NS, CLK_NS);
  localparam int DW_C   = ceilDiv(DW_NS, CLK_NS);
  localparam int WC_C   = ceilDiv(WC_NS, CLK_NS);
  localparam int AA_C   = ceilDiv(AA_NS, CLK_NS);
  localparam int RC_C   = ceilDiv(RC_NS, CLK_NS);
  // data is driven from the prepare phase on, so the strobe needs DW_C-1
  localparam int WR_ACT = maxInt(maxInt(WP_C, DW_C - 1), maxInt(WC_C - 2, 1));
  localparam int RD_ACT = maxInt(AA_C, maxInt(RC_C - 2, 1));
  localparam int CNT_W  = $clog2(maxInt(WR_ACT, RD_ACT) + 1);

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             opWr, nextWr, accept;
  logic             selR, weR, oeR, drvR, capR;

  always_comb begin
    accept    = reqValid && (state == ST_IDLE || state == ST_RECOVER);
    nextState = state;
    nextCnt   = cnt;
    nextWr    = accept ? reqWrite : opWr;
    case (state)
      ST_SETUP: begin
        nextState = ST_ACTIVE;
        nextCnt   = opWr ? CNT_W'(WR_ACT - 1) : CNT_W'(RD_ACT - 1);
      end
      ST_ACTIVE: begin
        if (cnt == '0) nextState = ST_RECOVER;
        else           nextCnt   = cnt - 1'b1;
      end
      default: nextState = accept ? ST_SETUP : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opWr  <= 1'b0;
      selR  <= 1'b0;
      weR   <= 1'b0;
      oeR   <= 1'b0;
      drvR  <= 1'b0;
      capR  <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      opWr  <= nextWr;
      selR  <= (nextState != ST_IDLE);
      weR   <= (nextState == ST_ACTIVE) && nextWr;
      oeR   <= (nextState == ST_ACTIVE) && !nextWr;
      drvR  <= (nextState != ST_IDLE) && nextWr;
      capR  <= (nextState == ST_ACTIVE) && !nextWr && (nextCnt == '0);
    end
  end

  assign reqReady = (state == ST_IDLE) || (state == ST_RECOVER);

  always_comb begin
    strb.take    = accept;
    strb.select  = selR;
    strb.weOn    = weR;
    strb.oeOn    = oeR;
    strb.drive   = drvR;
    strb.capture = capR;
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] sramDin,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCe1N,
  output logic              sramCe2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [LANES-1:0]  sramByteN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg, rdReg;
  logic [LANES-1:0]  maskReg;
  logic              rspReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      maskReg  <= '0;
      rdReg    <= '0;
      rspReg   <= 1'b0;
    end else begin
      if (strb.take) begin
        addrReg  <= reqAddr;
        maskReg  <= reqMask;
        if (reqWrite) wdataReg <= reqWdata;
      end
      if (strb.capture) rdReg <= sramDin;
      rspReg <= strb.capture;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign sramByteN[lane] = !(strb.select && maskReg[lane]);
  end

  assign sramAddr = addrReg;
  assign sramDout = wdataReg;
  assign sramDoe  = strb.drive;
  assign sramCe1N = !strb.select;
  assign sramCe2  = strb.select;
  assign sramWeN  = !strb.weOn;
  assign sramOeN  = !strb.oeOn;
  assign rspValid = rspReg;
  assign rspData  = rdReg;

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 50,
  parameter int DW_NS  = 30,
  parameter int WC_NS  = 70,
  parameter int AA_NS  = 70,
  parameter int RC_NS  = 70,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCe1N,
  output logic              sramCe2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [LANES-1:0]  sramByteN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  input  logic [DATA_W-1:0] sramDin
);

  seqStrb_t strb;

  asram_ctrl #(
    .CLK_NS(CLK_NS), .WP_NS(WP_NS), .DW_NS(DW_NS),
    .WC_NS(WC_NS), .AA_NS(AA_NS), .RC_NS(RC_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .sramDin(sramDin), .rspValid(rspValid), .rspData(rspData),
    .sramAddr(sramAddr), .sramCe1N(sramCe1N), .sramCe2(sramCe2),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramByteN(sramByteN),
    .sramDout(sramDout), .sramDoe(sramDoe)
  );

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 50
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCe1N,
  input logic              sramCe2,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramDoe
);

  localparam int WP_C = ceilDiv(WP_NS, CLK_NS);

  logic [7:0] weLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         weLowCnt <= '0;
    else if (!sramWeN) weLowCnt <= (weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 1'b1;
    else               weLowCnt <= '0;
  end

  AST_ADDR_HELD_UNDER_WE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> $stable(sramAddr)); // R2
  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (int'(weLowCnt) >= WP_C)); // R3
  AST_DRIVE_UNDER_WE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramDoe); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (!sramDoe && sramWeN)); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!sramWeN || !sramOeN) |-> !reqReady); // R9
  AST_WE_ENDS_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (!sramCe1N && sramCe2)); // R10

endmodule

bind asram_seq asram_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .WP_NS(WP_NS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .sramAddr(sramAddr), .sramCe1N(sramCe1N), .sramCe2(sramCe2),
  .sramWeN(sramWeN), .sramOeN(sramOeN), .sramDoe(sramDoe)
);

// File: tb/sim_asram_seq.sv
module sim_asram_seq;
  localparam int AW = 19, DW = 16, LN = 2;
  localparam int CLK_NS = 10;
  localparam int WP_C = (50 + CLK_NS - 1) / CLK_NS;
  localparam int DS_C = (30 + CLK_NS - 1) / CLK_NS;
  localparam int WC_C = (70 + CLK_NS - 1) / CLK_NS;
  localparam int AA_C = (70 + CLK_NS - 1) / CLK_NS;
  localparam int RC_C = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WR_ACT = 5;  // max(WP_C, DS_C-1, WC_C-2)
  localparam int RD_ACT = 7;  // max(AA_C, RC_C-2)

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [LN-1:0] reqMask = '0;
  logic rspValid, sramCe1N, sramCe2, sramWeN, sramOeN, sramDoe;
  logic [DW-1:0] rspData, sramDout, sramDin;
  logic [AW-1:0] sramAddr;
  logic [LN-1:0] sramByteN;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] refMem [64];
  logic [DW-1:0] modMem [64];
  logic [DW-1:0] expQ [$];

  always #5 clk = ~clk;

  asram_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rspValid(rspValid), .rspData(rspData),
    .sramAddr(sramAddr), .sramCe1N(sramCe1N), .sramCe2(sramCe2),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramByteN(sramByteN),
    .sramDout(sramDout), .sramDoe(sramDoe), .sramDin(sramDin)
  );

  function automatic logic [DW-1:0] laneMerge(input logic [DW-1:0] oldW,
      input logic [DW-1:0] newW, input logic [LN-1:0] m);
    return {m[1] ? newW[15:8] : oldW[15:8], m[0] ? newW[7:0] : oldW[7:0]};
  endfunction

  function automatic logic [DW-1:0] laneKeep(input logic [DW-1:0] w,
      input logic [LN-1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  // behavioural RAM with timing checks (cycle units)
  logic [AW-1:0] prevAddr;
  logic [DW-1:0] prevDout;
  int addrAge, dataAge, weLow;
  wire selNow = !sramCe1N && sramCe2;
  wire rdOk = selNow && !sramOeN && sramWeN && (addrAge >= AA_C - 1);
  assign sramDin = rdOk ? laneKeep(modMem[sramAddr[5:0]], ~sramByteN) : 16'hBAD0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      prevAddr <= '0; prevDout <= '0; addrAge <= 0; dataAge <= 0; weLow <= 0;
    end else begin
      if (sramAddr != prevAddr && !sramWeN) begin
        bad++; $display("FAIL R2 addr moved under WE: %h expected %h", sramAddr, prevAddr);
      end
      if (!sramOeN && sramDoe) begin
        bad++; $display("FAIL R6 bus fight: doe=%b expected 0", sramDoe);
      end
      addrAge  <= (sramAddr != prevAddr) ? 0 : ((addrAge < 1000) ? addrAge + 1 : addrAge);
      prevAddr <= sramAddr;
      if (sramDoe) dataAge <= (sramDout == prevDout && dataAge > 0) ? dataAge + 1 : 1;
      else         dataAge <= 0;
      prevDout <= sramDout;
      if (!sramWeN) weLow <= weLow + 1;
      else if (weLow > 0) begin
        total += 3;
        if (weLow < WP_C) begin
          bad++; $display("FAIL R3 WE low %0d expected >= %0d", weLow, WP_C);
        end
        if (dataAge < DS_C || !sramDoe) begin
          bad++; $display("FAIL R4 data age %0d doe %b expected >= %0d and 1", dataAge, sramDoe, DS_C);
        end
        if (!selNow) begin
          bad++; $display("FAIL R10 selects at WE rise %b%b expected 01", sramCe1N, sramCe2);
        end
        modMem[sramAddr[5:0]] <= laneMerge(modMem[sramAddr[5:0]], sramDout, ~sramByteN);
        weLow <= 0;
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rstN && rspValid && !done) begin
      total++;
      if (expQ.size() == 0) begin
        bad++; $display("FAIL R11 unexpected response %h expected none", rspData);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        if (rspData !== e) begin
          bad++; $display("FAIL R7 read data %h expected %h", rspData, e);
        end
      end
    end
  end

  int lastAcc = 0; bit lastWr = 1'b0, haveLast = 1'b0;

  task automatic doOp(input bit wr, input logic [5:0] a, input logic [DW-1:0] d,
                      input logic [LN-1:0] m, input bit b2b);
    int acc, sp;
    reqValid = 1'b1; reqWrite = wr; reqAddr = {13'b0, a}; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    acc = cyc;
    if (haveLast) begin
      sp = acc - lastAcc;
      total++;
      if (sp < (lastWr ? WC_C : RC_C)) begin
        bad++; $display("FAIL R5 spacing %0d expected >= %0d", sp, lastWr ? WC_C : RC_C);
      end
      if (b2b) begin
        total++;
        if (sp != (lastWr ? WR_ACT : RD_ACT) + 2) begin
          bad++; $display("FAIL R9 spacing %0d expected %0d", sp, (lastWr ? WR_ACT : RD_ACT) + 2);
        end
      end
    end
    if (wr) refMem[a] = laneMerge(refMem[a], d, m);
    else    expQ.push_back(laneKeep(refMem[a], m));
    @(negedge clk);
    reqValid = 1'b0;
    haveLast = 1'b1; lastAcc = acc; lastWr = wr;
  endtask

  task automatic checkIdle(input string tag);
    total++;
    if (!(sramCe1N && !sramCe2 && sramWeN && sramOeN && sramByteN == 2'b11 &&
          !sramDoe && reqReady && !rspValid)) begin
      bad++;
      $display("FAIL R1 %s pins ce1N=%b ce2=%b we=%b oe=%b be=%b doe=%b rdy=%b rsp=%b expected 1 0 1 1 11 0 1 0",
               tag, sramCe1N, sramCe2, sramWeN, sramOeN, sramByteN, sramDoe, reqReady, rspValid);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    bad++; $display("FAIL watchdog expired at cycle %0d expected finish", cyc);
    finishRun();
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    for (int i = 0; i < 64; i++) begin
      refMem[i] = 16'(i * 16'h0301) ^ 16'h5A3C;
      modMem[i] = refMem[i];
    end
    repeat (3) @(negedge clk);
    checkIdle("in reset");           // R1
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("after reset");        // R1
    // directed: R8 lane writes then full read
    doOp(1'b1, 6'd5, 16'hA1B2, 2'b01, 1'b0);
    doOp(1'b0, 6'd5, 16'h0, 2'b11, 1'b1);   // write -> read back to back, R9
    doOp(1'b1, 6'd6, 16'hC3D4, 2'b10, 1'b0);
    doOp(1'b0, 6'd6, 16'h0, 2'b11, 1'b1);
    doOp(1'b0, 6'd6, 16'h0, 2'b01, 1'b1);   // read -> read, R7 masked lane
    doOp(1'b1, 6'd6, 16'h1111, 2'b11, 1'b1); // read -> write
    doOp(1'b1, 6'd7, 16'h2222, 2'b11, 1'b1); // write -> write
    doOp(1'b0, 6'd7, 16'h0, 2'b11, 1'b1);
    repeat (12) @(negedge clk);
    checkIdle("after directed");     // R1
    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      doOp(1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)), 16'($urandom),
           2'($urandom_range(1, 3)), gap == 0);
    end
    repeat (15) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin      // R11
      bad++; $display("FAIL R11 pending reads %0d expected 0", expQ.size());
    end
    checkIdle("at end");             // R1
    finishRun();
  end
endmodule